// File: doc/BRIEF.md
# H-Bridge Command Decoder and Fault Latch

This block turns the logic-level control pins of a two-leg motor bridge into a drive state for each leg: high side on, low side on, or both off (high impedance). A leg request of 1 selects the high side and 0 the low side. A polarity input reverses the sense of both requests together. Two disable inputs force both legs off and report a fault. One is active high and the other active low. A wake input selects sleep or run.

The block also keeps an active-low status flag. A short-circuit pulse or an overtemperature indication latches both legs off and latches the flag low, whatever the requests do. The latch is cleared only by a falling edge on the active-high disable, a rising edge on the active-low disable, any change of the wake input, or reset. An overtemperature latch clears only if the temperature is also reported below its hysteresis point at that moment. Undervoltage turns the legs off and pulls the flag low for as long as it lasts, and does not latch.

Every asynchronous input passes through a synchronizer chain, `SYNC_STAGES` flops deep, before it is decoded or checked for edges.

Top module: `hb_cmd_guard`

## Requirements
- R1: During and after reset, while wake is low, both leg outputs are 2'b00 and `status_n` is 1.
- R2: Leg encoding: 2'b10 means high side on, 2'b01 means low side on, 2'b00 means off. 2'b11 is never produced.
- R3: When running with no disable and no fault, leg A drives high for `req_a`=1 and low for `req_a`=0. Leg B follows `req_b` the same way. This covers forward (1,0), reverse (0,1), freewheel low (0,0) and freewheel high (1,1). `status_n` is 1.
- R4: With `flip`=1, both requests are inverted before decoding.
- R5: `kill_hi`=1 or `kill_lo_n`=0, while awake, forces both legs to 2'b00 and `status_n` to 0.
- R6: `wake`=0 forces both legs to 2'b00 with `status_n`=1, even if disables, faults or undervoltage are present.
- R7: A `short_pulse` seen while awake latches both legs off and `status_n` low. The latch holds through any later change of the requests or of `flip`.
- R8: The latch clears on a 1-to-0 change of `kill_hi`, a 0-to-1 change of `kill_lo_n`, or any change of `wake`. A fault event in the same cycle as a clear wins over the clear.
- R9: An overtemperature latch clears on a clear event only while `temp_cool` is 1. Otherwise it stays set.
- R10: `undervolt`=1 turns both legs off and pulls `status_n` low without latching. The outputs return to the commanded state when it drops.
- R11: Every input reaches the outputs through exactly two register stages (default `SYNC_STAGES`=2). Latched faults take effect one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_a | input | 1 | Leg A level request |
| req_b | input | 1 | Leg B level request |
| flip | input | 1 | Inverts both requests when 1 |
| kill_hi | input | 1 | Disable, active high |
| kill_lo_n | input | 1 | Disable, active low |
| wake | input | 1 | 1 = run, 0 = sleep |
| undervolt | input | 1 | Supply below lockout level |
| overtemp | input | 1 | Junction above thermal limit |
| temp_cool | input | 1 | Junction below limit minus hysteresis |
| short_pulse | input | 1 | Short-circuit detection pulse |
| leg_a_drv | output | 2 | Leg A drive state |
| leg_b_drv | output | 2 | Leg B drive state |
| status_n | output | 1 | Fault flag, active low |

## Verification
All four request pairs are applied with and without polarity inversion, so that a swapped leg or an inversion applied to one leg only shows up as a mismatch. Each disable is used alone and as a clear edge. Separate clear tests then show which edge releases a short-circuit latch and which one leaves it in place. Overtemperature is cleared once while still hot and once after cooling, which separates a plain latch from a cooling-gated one. Undervoltage is raised and dropped to show that the outputs recover with no clear edge. Requests that toggle every cycle expose any error in the synchronizer depth.

// File: rtl/hb_cmd_pkg.sv
package hb_cmd_pkg;
   typedef enum logic [1:0] {
      DRV_OFF  = 2'b00,
      DRV_LOW  = 2'b01,
      DRV_HIGH = 2'b10
   } drive_e;

   localparam int IX_REQ_A  = 0;
   localparam int IX_REQ_B  = 1;
   localparam int IX_FLIP   = 2;
   localparam int IX_KHI    = 3;
   localparam int IX_KLO_N  = 4;
   localparam int IX_WAKE   = 5;
   localparam int IX_UV     = 6;
   localparam int IX_HOT    = 7;
   localparam int IX_COOL   = 8;
   localparam int IX_SHORT  = 9;
   localparam int N_SYNC    = 10;
endpackage

// File: rtl/hb_sync_chain.sv
module hb_sync_chain #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("hb_sync_chain: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("hb_sync_chain: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/hb_fault_hold.sv
module hb_fault_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic khi_s,
   input  logic klo_n_s,
   input  logic wake_s,
   input  logic short_s,
   input  logic hot_s,
   input  logic cool_s,
   output logic short_latched,
   output logic hot_latched
);
   logic prev_khi, prev_klo_n, prev_wake;
   logic rearm, set_short, set_hot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_khi   <= 1'b0;
         prev_klo_n <= 1'b0;
         prev_wake  <= 1'b0;
      end else begin
         prev_khi   <= khi_s;
         prev_klo_n <= klo_n_s;
         prev_wake  <= wake_s;
      end
   end

   assign rearm = (prev_khi & ~khi_s) | (~prev_klo_n & klo_n_s) | (prev_wake ^ wake_s);
   assign set_short = short_s & wake_s;
   assign set_hot   = hot_s & wake_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         short_latched <= 1'b0;
         hot_latched   <= 1'b0;
      end else begin
         short_latched <= set_short | (short_latched & ~rearm);
         hot_latched   <= set_hot | (hot_latched & ~(rearm & cool_s));
      end
   end

   a_r7_short_sets: assert property (@(posedge clk) disable iff (!rst_n)
      set_short |=> short_latched);
   a_r8_rearm_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (short_latched && rearm && !set_short) |=> !short_latched);
   a_r9_hot_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (hot_latched && !cool_s) |=> hot_latched);
endmodule

// File: rtl/hb_leg_decode.sv
module hb_leg_decode
   import hb_cmd_pkg::*;
#(
   parameter int LEGS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [LEGS-1:0]      req,
   input  logic                 flip,
   input  logic                 block,
   input  logic                 wake,
   output logic [LEGS-1:0][1:0] drv
);
   generate
      if (LEGS < 1) begin : g_bad_legs
         $error("hb_leg_decode: LEGS must be at least 1");
      end
      for (genvar i = 0; i < LEGS; i++) begin : g_leg
         logic lvl;
         assign lvl    = req[i] ^ flip;
         assign drv[i] = (!wake || block) ? DRV_OFF : (lvl ? DRV_HIGH : DRV_LOW);

         a_r2_no_both_on: assert property (@(posedge clk) disable iff (!rst_n)
            drv[i] != 2'b11);
         a_r6_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
            !wake |-> drv[i] == DRV_OFF);
      end
   endgenerate
endmodule

// File: rtl/hb_cmd_guard.sv
module hb_cmd_guard
   import hb_cmd_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_a,
   input  logic       req_b,
   input  logic       flip,
   input  logic       kill_hi,
   input  logic       kill_lo_n,
   input  logic       wake,
   input  logic       undervolt,
   input  logic       overtemp,
   input  logic       temp_cool,
   input  logic       short_pulse,
   output logic [1:0] leg_a_drv,
   output logic [1:0] leg_b_drv,
   output logic       status_n
);
   localparam int LEGS = 2;

   logic [N_SYNC-1:0]     raw, syn;
   logic [LEGS-1:0][1:0]  drv;
   logic                  short_l, hot_l, blocked, wake_s;

   always_comb begin
      raw            = '0;
      raw[IX_REQ_A]  = req_a;
      raw[IX_REQ_B]  = req_b;
      raw[IX_FLIP]   = flip;
      raw[IX_KHI]    = kill_hi;
      raw[IX_KLO_N]  = kill_lo_n;
      raw[IX_WAKE]   = wake;
      raw[IX_UV]     = undervolt;
      raw[IX_HOT]    = overtemp;
      raw[IX_COOL]   = temp_cool;
      raw[IX_SHORT]  = short_pulse;
   end

   hb_sync_chain #(.W(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw),
      .q     (syn)
   );

   assign wake_s = syn[IX_WAKE];

   hb_fault_hold u_hold (
      .clk           (clk),
      .rst_n         (rst_n),
      .khi_s         (syn[IX_KHI]),
      .klo_n_s       (syn[IX_KLO_N]),
      .wake_s        (wake_s),
      .short_s       (syn[IX_SHORT]),
      .hot_s         (syn[IX_HOT]),
      .cool_s        (syn[IX_COOL]),
      .short_latched (short_l),
      .hot_latched   (hot_l)
   );

   assign blocked = syn[IX_KHI] | ~syn[IX_KLO_N] | short_l | hot_l | syn[IX_UV];

   hb_leg_decode #(.LEGS(LEGS)) u_dec (
      .clk   (clk),
      .rst_n (rst_n),
      .req   ({syn[IX_REQ_B], syn[IX_REQ_A]}),
      .flip  (syn[IX_FLIP]),
      .block (blocked),
      .wake  (wake_s),
      .drv   (drv)
   );

   assign leg_a_drv = drv[0];
   assign leg_b_drv = drv[1];
   assign status_n  = ~wake_s | ~blocked;

   a_r5_disable_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_s && (syn[IX_KHI] || !syn[IX_KLO_N])) |-> (!status_n && leg_a_drv == DRV_OFF));
   a_r10_uv_off: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_s && syn[IX_UV]) |-> (!status_n && leg_b_drv == DRV_OFF));
   a_r7_latched_off: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_s && short_l) |-> (leg_a_drv == DRV_OFF && leg_b_drv == DRV_OFF));
endmodule

// File: tb/hb_cmd_guard_bench.sv
module hb_cmd_guard_bench;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n = 1'b0;
   logic req_a = 0, req_b = 0, flip = 0, kill_hi = 0, kill_lo_n = 0, wake = 0;
   logic undervolt = 0, overtemp = 0, temp_cool = 0, short_pulse = 0;
   logic [1:0] leg_a_drv, leg_b_drv;
   logic status_n;

   hb_cmd_guard u_hb_cmd_guard (
      .clk(clk), .rst_n(rst_n), .req_a(req_a), .req_b(req_b), .flip(flip),
      .kill_hi(kill_hi), .kill_lo_n(kill_lo_n), .wake(wake), .undervolt(undervolt),
      .overtemp(overtemp), .temp_cool(temp_cool), .short_pulse(short_pulse),
      .leg_a_drv(leg_a_drv), .leg_b_drv(leg_b_drv), .status_n(status_n));

   int    vecs = 0;
   int    bad  = 0;
   string tag  = "R1";
   bit    done = 0;

   // reference model: a 2-deep queue of sampled input words plus two fault bits
   logic [9:0] pipe [$];
   logic [9:0] prev_w;
   bit m_short, m_hot;

   function automatic logic [9:0] sample_inputs();
      return {short_pulse, temp_cool, overtemp, undervolt, wake, kill_lo_n,
              kill_hi, flip, req_b, req_a};
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe = {10'd0, 10'd0};
         prev_w = 10'd0;
         m_short = 0;
         m_hot = 0;
      end else begin
         logic [9:0] s;
         bit release_ev;
         s = pipe[0];
         release_ev = (prev_w[3] && !s[3]) || (!prev_w[4] && s[4]) || (prev_w[5] != s[5]);
         m_short = (s[9] && s[5]) || (m_short && !release_ev);
         m_hot   = (s[7] && s[5]) || (m_hot && !(release_ev && s[8]));
         prev_w = s;
         void'(pipe.pop_front());
         pipe.push_back(sample_inputs());
      end
   end

   task automatic check_one(string what, int act, int exp_v);
      vecs++;
      if (act != exp_v) begin
         bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp_v, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         logic [9:0] s;
         int ea, eb, es;
         bit off;
         s = pipe[0];
         if (!rst_n || !s[5]) begin
            ea = 0; eb = 0; es = 1;
         end else begin
            off = s[3] || !s[4] || m_short || m_hot || s[6];
            es = off ? 0 : 1;
            ea = off ? 0 : ((s[0] ^ s[2]) ? 2 : 1);
            eb = off ? 0 : ((s[1] ^ s[2]) ? 2 : 1);
         end
         check_one("leg_a", leg_a_drv, ea);
         check_one("leg_b", leg_b_drv, eb);
         check_one("status_n", status_n, es);
         // R2: the both-on code must never appear
         vecs++;
         if (leg_a_drv == 2'b11 || leg_b_drv == 2'b11) begin
            bad++;
            $display("FAIL R2 code: actual %b/%b expected not 11", leg_a_drv, leg_b_drv);
         end
      end
   end

   task automatic run(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      run(4);
      rst_n = 1'b1;
      tag = "R1"; run(4);
      kill_lo_n = 1; wake = 1;
      tag = "R3";
      for (int k = 0; k < 4; k++) begin
         req_a = k[0]; req_b = k[1]; run(4);
      end
      tag = "R4"; flip = 1;
      for (int k = 0; k < 4; k++) begin
         req_a = k[0]; req_b = k[1]; run(4);
      end
      flip = 0; req_a = 1; req_b = 0;
      tag = "R5"; kill_hi = 1; run(5);
      kill_hi = 0; run(4);
      kill_lo_n = 0; run(5);
      kill_lo_n = 1; run(4);
      tag = "R6"; wake = 0; kill_hi = 1; undervolt = 1; run(5);
      kill_hi = 0; undervolt = 0; wake = 1; run(5);
      tag = "R7"; short_pulse = 1; run(1); short_pulse = 0;
      for (int k = 0; k < 8; k++) begin
         req_a = k[0]; req_b = k[1]; flip = k[2]; run(2);
      end
      flip = 0;
      tag = "R8"; kill_hi = 1; run(3); kill_hi = 0; run(5);
      short_pulse = 1; run(1); short_pulse = 0; run(4);
      kill_lo_n = 0; run(3); kill_lo_n = 1; run(5);
      short_pulse = 1; run(1); short_pulse = 0; run(4);
      wake = 0; run(3); wake = 1; run(5);
      short_pulse = 1; kill_hi = 1; run(2); kill_hi = 0; run(1); short_pulse = 0; run(5);
      wake = 0; run(3); wake = 1; run(4);
      tag = "R9"; overtemp = 1; temp_cool = 0; run(3); overtemp = 0; run(3);
      kill_hi = 1; run(3); kill_hi = 0; run(5);
      temp_cool = 1; kill_hi = 1; run(3); kill_hi = 0; run(5);
      tag = "R10"; undervolt = 1; run(5); undervolt = 0; run(5);
      tag = "R11";
      for (int k = 0; k < 12; k++) begin
         req_a = ~req_a; if (k % 3 == 0) req_b = ~req_b; run(1);
      end
      run(4);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
         $finish;
      end
   end
endmodule